// File: doc/BRIEF.md
# Sleep and Wake-up Controller

This block puts a small microcontroller core into a power-down state and brings it back out. When the core issues a sleep command, the block drops the core clock enable and clears the watchdog count. It also updates two status flags. One flag shows that power-down was entered. The other shows whether a watchdog time-out has happened.

While the core is asleep, the block watches three wake sources: a device reset, a watchdog time-out, and any peripheral interrupt flag whose own enable bit is set. A reset restarts the core at the reset address. A watchdog wake or an interrupt wake resumes at the instruction that follows the sleep instruction. That instruction was already prefetched.

The global interrupt enable has no say in whether an interrupt wakes the core. It only decides what happens after the resume. If it is set, the core runs the prefetched instruction and then takes a one-cycle vector request to the interrupt address. With that request the block asks for the global enable to be cleared and supplies the return address (sleep address + 2). A sleep command that arrives in the cycle when a pending vector is issued is ignored.

Top module: `sleep_wake_ctl`

## Requirements
- R1: After power-on reset (por_n low): core_clk_en=1, pd_flag=1, to_flag=1, wdt_count=0, no request pulse, and pc_out equals RST_VEC (0).
- R2: In the cycle after an accepted sleep_req, core_clk_en=0, pd_flag=0, to_flag=1 and wdt_count=0. pd_flag stays 0 for as long as the core is asleep.
- R3: With wdt_en=1, every wdt_tick cycle adds 1 to wdt_count, and the count keeps running during sleep. A tick at the all-ones count is a time-out, and the count wraps to 0. With wdt_en=0 the count holds.
- R4: A watchdog time-out while asleep wakes the core. In the next cycle core_clk_en=1, resume_req=1, pc_out = sleep address + 1 (modulo 2^PC_W), to_flag=0, and pd_flag stays 0.
- R5: An interrupt wakes the core only when some bit is set in both irq_flag and irq_en, whatever the value of gie. Flags without their enable leave core_clk_en at 0.
- R6: An interrupt wake with gie=0 gives resume_req=1 and pc_out = sleep address + 1 in the cycle after detection. No vector_req follows.
- R7: An interrupt wake with gie=1 gives the resume pulse first. In the following cycle the block gives vector_req=1 and gie_clr=1, with pc_out=VEC_ADDR (0x004) and ret_addr = sleep address + 2 (modulo 2^PC_W).
- R8: dev_rst restarts the core. In the next cycle restart_req=1, core_clk_en=1, pc_out=RST_VEC and wdt_count=0, while pd_flag and to_flag keep their values.
- R9: A watchdog time-out while awake restarts the core. In the next cycle restart_req=1, pc_out=RST_VEC, to_flag=0 and pd_flag=1.
- R10: Wake sources seen in the same cycle are ranked dev_rst first, then the watchdog, then interrupts. A watchdog wake that coincides with an interrupt wake schedules no vector.
- R11: sleep_req is ignored while asleep: the resume address comes from the first sleep command. While wdt_en=0, ticks cannot wake the core.
- R12: resume_req, vector_req and restart_req are single-cycle pulses, and at most one of them is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| dev_rst | input | 1 | Synchronous device reset request |
| sleep_req | input | 1 | Sleep command from the core |
| sleep_pc | input | PC_W | Address of the sleep instruction |
| wdt_en | input | 1 | Watchdog enable |
| wdt_tick | input | 1 | Watchdog prescaler tick |
| irq_flag | input | N_IRQ | Peripheral interrupt flags |
| irq_en | input | N_IRQ | Individual interrupt enables |
| gie | input | 1 | Global interrupt enable |
| core_clk_en | output | 1 | Core clock enable |
| pd_flag | output | 1 | Power-down status flag |
| to_flag | output | 1 | Time-out status flag (0 after a time-out) |
| wdt_count | output | WDT_W | Watchdog count |
| resume_req | output | 1 | Resume at pc_out |
| vector_req | output | 1 | Branch to the interrupt address |
| gie_clr | output | 1 | Request to clear the global interrupt enable |
| restart_req | output | 1 | Restart at the reset address |
| pc_out | output | PC_W | Target address of the current request |
| ret_addr | output | PC_W | Return address saved on a vector |

## Verification
The hardest case to reach is a watchdog time-out that falls in the same cycle as an enabled interrupt. The count has to sit at all-ones, asleep, at the exact moment the interrupt is presented. The bench uses a narrow watchdog so it can step the count to its top with single ticks while no interrupt is enabled. It then raises the tick and the interrupt together and checks that the time-out wins and no vector is issued. The two address wrap cases are reached by putting the sleep instruction at the last and second-to-last addresses.

// File: rtl/sleep_wake_ctl.sv
module sleep_wake_ctl #(
  parameter int PC_W  = 11,
  parameter int N_IRQ = 4,
  parameter int WDT_W = 8,
  parameter logic [PC_W-1:0] VEC_ADDR = 'h4,
  parameter logic [PC_W-1:0] RST_VEC  = 'h0
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             dev_rst,
  input  logic             sleep_req,
  input  logic [PC_W-1:0]  sleep_pc,
  input  logic             wdt_en,
  input  logic             wdt_tick,
  input  logic [N_IRQ-1:0] irq_flag,
  input  logic [N_IRQ-1:0] irq_en,
  input  logic             gie,
  output logic             core_clk_en,
  output logic             pd_flag,
  output logic             to_flag,
  output logic [WDT_W-1:0] wdt_count,
  output logic             resume_req,
  output logic             vector_req,
  output logic             gie_clr,
  output logic             restart_req,
  output logic [PC_W-1:0]  pc_out,
  output logic [PC_W-1:0]  ret_addr
);

  logic            asleep;
  logic            vec_pend;
  logic [PC_W-1:0] next_pc;

  wire wdt_to    = wdt_en & wdt_tick & (&wdt_count);
  wire irq_hit   = |(irq_flag & irq_en);
  wire awake_to  = ~asleep & wdt_to & ~dev_rst;
  wire go_sleep  = ~asleep & sleep_req & ~dev_rst & ~wdt_to & ~vec_pend;
  wire wake_wdt  = asleep & wdt_to & ~dev_rst;
  wire wake_irq  = asleep & irq_hit & ~wdt_to & ~dev_rst;

  assign core_clk_en = ~asleep;
  assign gie_clr     = vector_req;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      wdt_count <= '0;
    end else if (dev_rst || go_sleep || awake_to) begin
      wdt_count <= '0;
    end else if (wdt_en && wdt_tick) begin
      wdt_count <= wdt_count + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      asleep      <= 1'b0;
      pd_flag     <= 1'b1;
      to_flag     <= 1'b1;
      resume_req  <= 1'b0;
      vector_req  <= 1'b0;
      restart_req <= 1'b0;
      vec_pend    <= 1'b0;
      next_pc     <= RST_VEC;
      pc_out      <= RST_VEC;
      ret_addr    <= RST_VEC;
    end else begin
      resume_req  <= 1'b0;
      vector_req  <= 1'b0;
      restart_req <= 1'b0;
      if (dev_rst) begin
        asleep      <= 1'b0;
        vec_pend    <= 1'b0;
        restart_req <= 1'b1;
        pc_out      <= RST_VEC;
      end else if (awake_to) begin
        vec_pend    <= 1'b0;
        restart_req <= 1'b1;
        pc_out      <= RST_VEC;
        to_flag     <= 1'b0;
        pd_flag     <= 1'b1;
      end else if (go_sleep) begin
        asleep  <= 1'b1;
        pd_flag <= 1'b0;
        to_flag <= 1'b1;
        next_pc <= sleep_pc + 1'b1;
      end else if (wake_wdt || wake_irq) begin
        asleep     <= 1'b0;
        resume_req <= 1'b1;
        pc_out     <= next_pc;
        vec_pend   <= wake_irq & gie;
        if (wake_wdt) to_flag <= 1'b0;
      end else if (vec_pend) begin
        vec_pend   <= 1'b0;
        vector_req <= 1'b1;
        pc_out     <= VEC_ADDR;
        ret_addr   <= next_pc + 1'b1;
      end
    end
  end

  AST_SLEEP_ENTRY: assert property (@(posedge clk) disable iff (!por_n)
    go_sleep |=> (!core_clk_en && !pd_flag && to_flag && wdt_count == '0)); // R2
  AST_ASLEEP_PD: assert property (@(posedge clk) disable iff (!por_n)
    !core_clk_en |-> !pd_flag); // R2
  AST_WDT_STEP: assert property (@(posedge clk) disable iff (!por_n)
    (wdt_en && wdt_tick && !dev_rst && !go_sleep && !awake_to)
      |=> wdt_count == WDT_W'($past(wdt_count) + 1'b1)); // R3
  AST_WAKE_REQ: assert property (@(posedge clk) disable iff (!por_n)
    $rose(core_clk_en) |-> (resume_req || restart_req)); // R4
  AST_TO_FALL: assert property (@(posedge clk) disable iff (!por_n)
    $fell(to_flag) |-> (resume_req || restart_req)); // R4
  AST_MASKED_STAY: assert property (@(posedge clk) disable iff (!por_n)
    (!core_clk_en && !dev_rst && !wdt_to && !irq_hit) |=> !core_clk_en); // R5
  AST_VEC_SEQ: assert property (@(posedge clk) disable iff (!por_n)
    vector_req |-> ($past(resume_req) && pc_out == VEC_ADDR)); // R7
  AST_REQ_EXCL: assert property (@(posedge clk) disable iff (!por_n)
    $onehot0({resume_req, vector_req, restart_req})); // R12

endmodule

// File: tb/sim_sleep_wake_ctl.sv
module sim_sleep_wake_ctl;
  localparam int PC_W = 11;
  localparam int N_IRQ = 4;
  localparam int WDT_W = 3;

  logic clk = 1'b0;
  logic por_n = 1'b0;
  logic dev_rst = 1'b0, sleep_req = 1'b0, wdt_en = 1'b0, wdt_tick = 1'b0, gie = 1'b0;
  logic [PC_W-1:0] sleep_pc = '0;
  logic [N_IRQ-1:0] irq_flag = '0, irq_en = '0;
  logic core_clk_en, pd_flag, to_flag, resume_req, vector_req, gie_clr, restart_req;
  logic [WDT_W-1:0] wdt_count;
  logic [PC_W-1:0] pc_out, ret_addr;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  sleep_wake_ctl #(.PC_W(PC_W), .N_IRQ(N_IRQ), .WDT_W(WDT_W)) u0 (
    .clk(clk), .por_n(por_n), .dev_rst(dev_rst), .sleep_req(sleep_req), .sleep_pc(sleep_pc),
    .wdt_en(wdt_en), .wdt_tick(wdt_tick), .irq_flag(irq_flag), .irq_en(irq_en), .gie(gie),
    .core_clk_en(core_clk_en), .pd_flag(pd_flag), .to_flag(to_flag), .wdt_count(wdt_count),
    .resume_req(resume_req), .vector_req(vector_req), .gie_clr(gie_clr),
    .restart_req(restart_req), .pc_out(pc_out), .ret_addr(ret_addr));

  // {gie, flag, en, pc, wake, vector}
  localparam logic [21:0] TBL [0:5] = '{
    {1'b0, 4'b0001, 4'b0001, 11'h010, 1'b1, 1'b0},
    {1'b1, 4'b0100, 4'b0100, 11'h123, 1'b1, 1'b1},
    {1'b0, 4'b1000, 4'b0111, 11'h055, 1'b0, 1'b0},
    {1'b1, 4'b0011, 4'b1100, 11'h200, 1'b0, 1'b0},
    {1'b1, 4'b1010, 4'b0010, 11'h7FE, 1'b1, 1'b1},
    {1'b0, 4'b1111, 4'b1111, 11'h7FF, 1'b1, 1'b0}
  };

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic enter_sleep(input logic [PC_W-1:0] pc);
    sleep_req = 1'b1;
    sleep_pc = pc;
    tick();
    sleep_req = 1'b0;
    chk("R2 clk_en", core_clk_en, 0);
    chk("R2 pd", pd_flag, 0);
    chk("R2 to", to_flag, 1);
    chk("R2 wdt", wdt_count, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #23;
    chk("R1 clk_en", core_clk_en, 1);
    chk("R1 pd", pd_flag, 1);
    chk("R1 to", to_flag, 1);
    por_n = 1'b1;
    tick();
    chk("R1 wdt", wdt_count, 0);
    chk("R1 req", {resume_req, vector_req, restart_req}, 0);
    chk("R1 pc", pc_out, 0);

    for (int i = 0; i < 6; i++) begin
      logic [PC_W-1:0] p;
      p = TBL[i][12:2];
      enter_sleep(p);
      gie = TBL[i][21];
      irq_flag = TBL[i][20:17];
      irq_en = TBL[i][16:13];
      tick();
      irq_flag = '0;
      irq_en = '0;
      if (TBL[i][1]) begin
        chk("R5 wake", core_clk_en, 1);
        chk("R6 resume", resume_req, 1);
        chk("R6 pc", pc_out, 32'(PC_W'(p + 1)));
        chk("R2 pd kept", pd_flag, 0);
        tick();
        chk("R7 vector", vector_req, TBL[i][0]);
        chk("R7 gie_clr", gie_clr, TBL[i][0]);
        chk("R12 resume pulse", resume_req, 0);
        if (TBL[i][0]) begin
          chk("R7 vec pc", pc_out, 4);
          chk("R7 ret", ret_addr, 32'(PC_W'(p + 2)));
        end
      end else begin
        chk("R5 masked", core_clk_en, 0);
        chk("R5 no req", resume_req, 0);
        gie = 1'b0;
        irq_flag = 4'b0001;
        irq_en = 4'b0001;
        tick();
        irq_flag = '0;
        irq_en = '0;
        chk("R5 exit", resume_req, 1);
      end
      gie = 1'b0;
      tick();
    end

    // R11: sleep_req while asleep ignored
    enter_sleep(11'h030);
    sleep_req = 1'b1;
    sleep_pc = 11'h444;
    tick();
    sleep_req = 1'b0;
    chk("R11 asleep", core_clk_en, 0);
    irq_flag = 4'b0010;
    irq_en = 4'b0010;
    tick();
    irq_flag = '0;
    irq_en = '0;
    chk("R11 pc first", pc_out, 11'h031);
    tick();

    // R11: ticks with watchdog disabled
    enter_sleep(11'h040);
    wdt_tick = 1'b1;
    repeat (12) tick();
    wdt_tick = 1'b0;
    chk("R11 no wdt wake", core_clk_en, 0);
    chk("R3 hold", wdt_count, 0);

    // R8: device reset from sleep
    dev_rst = 1'b1;
    tick();
    dev_rst = 1'b0;
    chk("R8 restart", restart_req, 1);
    chk("R8 clk_en", core_clk_en, 1);
    chk("R8 pc", pc_out, 0);
    chk("R8 pd kept", pd_flag, 0);
    chk("R8 to kept", to_flag, 1);
    tick();

    // R3/R4: watchdog wake
    wdt_en = 1'b1;
    enter_sleep(11'h100);
    wdt_tick = 1'b1;
    repeat (7) tick();
    chk("R3 count", wdt_count, 7);
    chk("R3 still asleep", core_clk_en, 0);
    tick();
    wdt_tick = 1'b0;
    chk("R4 wake", core_clk_en, 1);
    chk("R4 resume", resume_req, 1);
    chk("R4 pc", pc_out, 11'h101);
    chk("R4 to", to_flag, 0);
    chk("R4 pd", pd_flag, 0);
    chk("R3 wrap", wdt_count, 0);
    tick();

    // R10: watchdog beats interrupt
    enter_sleep(11'h300);
    wdt_tick = 1'b1;
    repeat (7) tick();
    gie = 1'b1;
    irq_flag = 4'b0001;
    irq_en = 4'b0001;
    tick();
    wdt_tick = 1'b0;
    irq_flag = '0;
    irq_en = '0;
    gie = 1'b0;
    chk("R10 resume", resume_req, 1);
    chk("R10 to", to_flag, 0);
    tick();
    chk("R10 no vector", vector_req, 0);

    // R10: reset beats interrupt
    enter_sleep(11'h310);
    irq_flag = 4'b0001;
    irq_en = 4'b0001;
    dev_rst = 1'b1;
    tick();
    dev_rst = 1'b0;
    irq_flag = '0;
    irq_en = '0;
    chk("R10 restart", restart_req, 1);
    chk("R10 no resume", resume_req, 0);
    chk("R10 pc", pc_out, 0);
    tick();

    // R9: time-out while awake
    wdt_tick = 1'b1;
    repeat (7) tick();
    chk("R9 awake", core_clk_en, 1);
    tick();
    wdt_tick = 1'b0;
    chk("R9 restart", restart_req, 1);
    chk("R9 to", to_flag, 0);
    chk("R9 pd", pd_flag, 1);
    chk("R9 pc", pc_out, 0);
    tick();
    chk("R12 restart pulse", restart_req, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule